// File: doc/BRIEF.md
# Two-Operand Load-Store Core

A small 32-bit processor core that runs a four-instruction set of word load, word store, add and exclusive-or. Every instruction is one 32-bit word holding a 6-bit operation code and two 5-bit register indices. The first index (op0) is both a source and the destination, so arithmetic overwrites its left operand. Load and store reach memory indirectly: the byte address is the contents of the register named by the second index (op1).

The core has thirty-two 32-bit general registers, a 32-bit program counter and a 32-bit flags word. Instruction fetch and data access share one memory port. The port has a request, a write enable, a 32-bit address and data in each direction, and a ready return. Each instruction runs in a fixed sequence of phases: fetch, then execute, then a memory phase that only load and store use, then write-back. The core stays in a phase with an access pending until the memory raises ready.

Top module: `lsc_core`

## Requirements
- R1: While reset is held and right after it is released, the flags output is zero and the core requests a read (mem_req 1, mem_we 0) at address 0. All general registers also start at zero.
- R2: Decode uses bits 5:0 as the operation code, bits 10:6 as op0 and bits 15:11 as op1. Bits 31:16 of the instruction word have no effect.
- R3: Code 0x00 reads the word at the address held in R[op1] and writes it to R[op0]. The flags are left unchanged.
- R4: Code 0x01 issues a write (mem_we 1) of R[op0] to the address held in R[op1]. It writes no register and leaves the flags unchanged.
- R5: Code 0x02 sets R[op0] = R[op0] + R[op1] modulo 2^32. The flags become: bit 0 set when the result is zero, bit 1 set to the carry out of bit 31, bit 2 set to result bit 31, and every other bit cleared.
- R6: Code 0x03 sets R[op0] = R[op0] ^ R[op1]. The flags become: bit 0 set when the result is zero, bit 2 set to result bit 31, bit 1 and every other bit cleared.
- R7: Codes 0x04 to 0x3F write no register and set flags bit 31 while keeping the other flag bits. The program counter still advances.
- R8: Each instruction makes one fetch at the program counter, and the counter then advances by 4. Only load and store make a second access, a data access between that fetch and the next one. Successive fetch addresses therefore step by 4 from 0.
- R9: While an access waits for ready, mem_req stays high and mem_addr, mem_we and mem_wdata hold steady. The core does not leave its phase.
- R10: R0 is an ordinary writable register. When op0 equals op1, both operands read the value the register held before the instruction. A load whose destination is its own address register takes the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory access requested this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Data for a write access |
| mem_rdata | input | 32 | Data returned for a read access |
| mem_ready | input | 1 | Memory completes the pending access on this edge |
| flags | output | 32 | Current flags word |

## Verification
In the execute phase, one register can be the source of both operands, and the same register can also be the write-back target. Memory can also accept a request on its first cycle or keep it waiting for many. Directed programs cover these cases: ADD R0,R1 followed by STW R0,R0, ADD R1,R1 followed by STW R1,R1, and LDW R1,R1 followed by STW R1,R1, run with a five-cycle memory latency. Each result is judged by the address and data of the store that follows. While the memory stalls, the bench compares every waiting cycle's address and write enable with the first cycle of the wait. It also models independently which access is a fetch and which is a data access.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    parameter int XLEN   = 32;
    parameter int NREG   = 32;
    parameter int OPC_W  = 6;
    localparam int RIDX_W = $clog2(NREG);
    localparam int ILEN_B = XLEN / 8;

    localparam int F_ZERO  = 0;
    localparam int F_CARRY = 1;
    localparam int F_SIGN  = 2;
    localparam int F_UNDEF = XLEN - 1;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h01;
    localparam logic [OPC_W-1:0] OPC_ADD   = 6'h02;
    localparam logic [OPC_W-1:0] OPC_XOR   = 6'h03;

    typedef enum logic [2:0] {
        K_LOAD,
        K_STORE,
        K_ADD,
        K_XOR,
        K_UNDEF
    } kind_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_EXEC,
        ST_MEM,
        ST_WB
    } phase_e;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] src;
    } instr_t;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic [XLEN-1:0] flags;
        logic            wr_reg;
    } exres_t;

    function automatic instr_t decode(input logic [XLEN-1:0] w);
        instr_t d;
        d.dst = w[OPC_W +: RIDX_W];
        d.src = w[OPC_W + RIDX_W +: RIDX_W];
        case (w[OPC_W-1:0])
            OPC_LOAD:  d.kind = K_LOAD;
            OPC_STORE: d.kind = K_STORE;
            OPC_ADD:   d.kind = K_ADD;
            OPC_XOR:   d.kind = K_XOR;
            default:   d.kind = K_UNDEF;
        endcase
        return d;
    endfunction

    function automatic exres_t execute(input kind_e k,
                                       input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b,
                                       input logic [XLEN-1:0] fin);
        exres_t        r;
        logic [XLEN:0] sum;
        sum      = {1'b0, a} + {1'b0, b};
        r.value  = a;
        r.flags  = fin;
        r.wr_reg = 1'b0;
        case (k)
            K_ADD: begin
                r.value          = sum[XLEN-1:0];
                r.flags          = '0;
                r.flags[F_CARRY] = sum[XLEN];
                r.wr_reg         = 1'b1;
            end
            K_XOR: begin
                r.value  = a ^ b;
                r.flags  = '0;
                r.wr_reg = 1'b1;
            end
            K_UNDEF: r.flags[F_UNDEF] = 1'b1;
            default: ;
        endcase
        if (k == K_ADD || k == K_XOR) begin
            r.flags[F_ZERO] = (r.value == '0);
            r.flags[F_SIGN] = r.value[XLEN-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
    parameter int N  = 32,
    parameter int W  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_a_idx,
    output logic [W-1:0]  rd_a_data,
    input  logic [AW-1:0] rd_b_idx,
    output logic [W-1:0]  rd_b_data
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = regs[rd_a_idx];
    assign rd_b_data = regs[rd_b_idx];

    // R10: a written register reads back the written value on the next cycle
    p_rf_readback_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en && rd_a_idx == wr_idx ##1 $stable(rd_a_idx) |-> rd_a_data == $past(wr_data));

endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
    import lsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            mem_ready,
    input  logic [XLEN-1:0] fetch_word,
    output phase_e          phase,
    output logic [XLEN-1:0] pc,
    output instr_t          instr
);

    localparam logic [XLEN-1:0] PC_STEP = XLEN'(ILEN_B);

    logic [XLEN-1:0] ir;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_FETCH;
            pc    <= '0;
            ir    <= '0;
        end else begin
            case (phase)
                ST_FETCH: if (mem_ready) begin
                    ir    <= fetch_word;
                    phase <= ST_EXEC;
                end
                ST_EXEC: phase <= (instr.kind == K_LOAD || instr.kind == K_STORE)
                                  ? ST_MEM : ST_WB;
                ST_MEM: if (mem_ready) phase <= ST_WB;
                default: begin
                    pc    <= pc + PC_STEP;
                    phase <= ST_FETCH;
                end
            endcase
        end
    end

    assign instr = decode(ir);

    // R8: the counter only ever moves forward by one instruction word
    p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc) |-> pc == $past(pc) + PC_STEP);

    // R8: register and non-memory ops skip the memory phase
    p_alu_skips_mem_r8: assert property (@(posedge clk) disable iff (rst)
        phase == ST_EXEC && instr.kind != K_LOAD && instr.kind != K_STORE
        |=> phase == ST_WB);

    // R9: a waiting access keeps its phase
    p_wait_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FETCH || phase == ST_MEM) && !mem_ready |=> $stable(phase));

endmodule

// File: rtl/lsc_core.sv
module lsc_core
    import lsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic [XLEN-1:0] flags
);

    phase_e          phase;
    logic [XLEN-1:0] pc;
    instr_t          instr;
    logic [XLEN-1:0] rd_a, rd_b;
    logic [XLEN-1:0] opa_q, opb_q, ld_q, flags_q;
    exres_t          res_q;
    logic            rf_we;
    logic [XLEN-1:0] rf_wdata;

    lsc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mem_ready  (mem_ready),
        .fetch_word (mem_rdata),
        .phase      (phase),
        .pc         (pc),
        .instr      (instr)
    );

    lsc_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (rf_we),
        .wr_idx    (instr.dst),
        .wr_data   (rf_wdata),
        .rd_a_idx  (instr.dst),
        .rd_a_data (rd_a),
        .rd_b_idx  (instr.src),
        .rd_b_data (rd_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q   <= '0;
            opb_q   <= '0;
            ld_q    <= '0;
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            if (phase == ST_EXEC) begin
                opa_q <= rd_a;
                opb_q <= rd_b;
                res_q <= execute(instr.kind, rd_a, rd_b, flags_q);
            end
            if (phase == ST_MEM && mem_ready) ld_q <= mem_rdata;
            if (phase == ST_WB) flags_q <= res_q.flags;
        end
    end

    always_comb begin
        rf_we    = (phase == ST_WB) && (res_q.wr_reg || instr.kind == K_LOAD);
        rf_wdata = (instr.kind == K_LOAD) ? ld_q : res_q.value;
    end

    assign mem_req   = (phase == ST_FETCH) || (phase == ST_MEM);
    assign mem_we    = (phase == ST_MEM) && (instr.kind == K_STORE);
    assign mem_addr  = (phase == ST_MEM) ? opb_q : pc;
    assign mem_wdata = opa_q;
    assign flags     = flags_q;

    // R9: a pending request holds its attributes until accepted
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_we) && $stable(mem_wdata));

    // R3, R4: memory instructions leave the flags alone
    p_ldst_flags_keep_r3: assert property (@(posedge clk) disable iff (rst)
        phase == ST_WB && (instr.kind == K_LOAD || instr.kind == K_STORE)
        |=> $stable(flags_q));

    // R7: an unknown code marks the top flag bit
    p_undef_marks_r7: assert property (@(posedge clk) disable iff (rst)
        phase == ST_WB && instr.kind == K_UNDEF |=> flags_q[F_UNDEF]);

    // R6: exclusive-or never reports a carry
    p_xor_no_carry_r6: assert property (@(posedge clk) disable iff (rst)
        phase == ST_WB && instr.kind == K_XOR |=> !flags_q[F_CARRY]);

    // R4: only the store produces write traffic
    p_write_is_store_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req && mem_addr == opb_q);

endmodule

// File: tb/tb_lsc_core.sv
`timescale 1ns/100ps
module tb_lsc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, flags;

    always #2.5 clk = ~clk;

    lsc_core dut (
        .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .flags(flags)
    );

    // bench memory: 256 words, upper address bits alias
    logic [31:0] mem [256];
    assign mem_rdata = mem[mem_addr[9:2]];

    int          n_chk = 0, n_fail = 0;
    int          lat = 0, wait_cnt = 0;
    logic        rdy = 1'b0, waiting = 1'b0, expect_fetch = 1'b1;
    logic [31:0] epc = 0, hold_addr = 0;
    logic        hold_we = 1'b0;
    int          seq_err = 0, stall_err = 0, st_cnt = 0;
    logic [31:0] st_addr [4];
    logic [31:0] st_data [4];

    assign mem_ready = rdy;

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] d,
                                        input logic [4:0] s, input logic [15:0] up);
        return {up, s, d, op};
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            rdy = 1'b0; wait_cnt = 0; waiting = 1'b0; expect_fetch = 1'b1;
            epc = 0; seq_err = 0; stall_err = 0; st_cnt = 0;
        end else if (rdy) begin
            rdy = 1'b0;
        end else if (mem_req) begin
            if (!waiting) begin
                hold_addr = mem_addr; hold_we = mem_we; waiting = 1'b1;
            end else if (mem_addr !== hold_addr || mem_we !== hold_we) begin
                stall_err++;
            end
            if (wait_cnt >= lat) begin
                rdy = 1'b1; wait_cnt = 0; waiting = 1'b0;
                if (expect_fetch) begin
                    if (mem_we !== 1'b0 || mem_addr !== epc) seq_err++;
                    epc = epc + 4;
                    expect_fetch = !(mem_rdata[5:0] <= 6'h01);
                end else begin
                    expect_fetch = 1'b1;
                    if (mem_we) begin
                        if (st_cnt < 4) begin
                            st_addr[st_cnt] = mem_addr;
                            st_data[st_cnt] = mem_wdata;
                        end
                        st_cnt++;
                        mem[mem_addr[9:2]] = mem_wdata;
                    end
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    task automatic run_prog(input int latency, input int nstore);
        @(posedge clk); #1;
        rst = 1'b1; lat = latency;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int k = 0; k < 4000 && st_cnt < nstore; k++) begin
            @(posedge clk); #1;
        end
        if (st_cnt < nstore) check("R8 program timeout", st_cnt, nstore);
        repeat (12) @(posedge clk);
        #1;
    endtask

    // op, upper bits, A, B, expected result, expected flags
    localparam logic [149:0] VEC [9] = '{
        {6'h02, 16'h0000, 32'h0000_1234, 32'h0000_0111, 32'h0000_1345, 32'h0000_0000},
        {6'h02, 16'h0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 32'h0000_0003},
        {6'h02, 16'h0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h0000_0004},
        {6'h02, 16'hFFFF, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 32'h0000_0003},
        {6'h03, 16'h0000, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'h0000_0000, 32'h0000_0001},
        {6'h03, 16'h5A5A, 32'h0F0F_0000, 32'hF000_0000, 32'hFF0F_0000, 32'h0000_0004},
        {6'h04, 16'h0000, 32'h1111_2222, 32'h3333_4444, 32'h1111_2222, 32'h8000_0000},
        {6'h3F, 16'hABCD, 32'hCAFE_F00D, 32'h0000_0001, 32'hCAFE_F00D, 32'h8000_0000},
        {6'h02, 16'h0000, 32'hF000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0002}
    };

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        clear_mem();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state seen at the ports
        check("R1 req", {31'b0, mem_req}, 32'd1);
        check("R1 we", {31'b0, mem_we}, 32'd0);
        check("R1 addr", mem_addr, 32'h0);
        check("R1 flags", flags, 32'h0);

        // vector walk: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 9; v++) begin
            logic [149:0] row;
            row = VEC[v];
            clear_mem();
            mem[0]  = enc(6'h00, 5'd1, 5'd0, 16'h0);      // R1 <- 0x40 (R1 starts at 0)
            mem[1]  = enc(6'h00, 5'd2, 5'd1, 16'h0);      // R2 <- A
            mem[2]  = enc(6'h02, 5'd5, 5'd1, 16'h0);      // R5 = 0x40
            mem[3]  = enc(6'h02, 5'd5, 5'd1, 16'h0);      // R5 = 0x80
            mem[4]  = enc(6'h00, 5'd3, 5'd5, 16'h0);      // R3 <- B
            mem[5]  = enc(6'h02, 5'd5, 5'd1, 16'h0);      // R5 = 0xC0
            mem[6]  = enc(row[149:144], 5'd2, 5'd3, row[143:128]);
            mem[7]  = enc(6'h01, 5'd2, 5'd5, 16'h0);      // store R2 at 0xC0
            mem[16] = row[127:96];
            mem[32] = row[95:64];
            run_prog(v % 3, 1);
            check($sformatf("R5/R6/R7/R2 result v%0d", v), st_data[0], row[63:32]);
            check($sformatf("R4 store addr v%0d", v), st_addr[0], 32'h0000_00C0);
            check($sformatf("R5/R6/R7 flags after R3 loads v%0d", v), flags, row[31:0]);
            check($sformatf("R8 fetch order v%0d", v), seq_err, 0);
        end

        // R10: R0 written, then ADD R1,R1 doubling
        clear_mem();
        mem[0] = enc(6'h00, 5'd1, 5'd0, 16'h0);
        mem[1] = enc(6'h02, 5'd0, 5'd1, 16'h0);
        mem[2] = enc(6'h01, 5'd0, 5'd0, 16'h0);
        mem[3] = enc(6'h02, 5'd1, 5'd1, 16'h0);
        mem[4] = enc(6'h01, 5'd1, 5'd1, 16'h0);
        run_prog(1, 2);
        check("R10 r0 store addr", st_addr[0], 32'h40);
        check("R10 r0 store data", st_data[0], 32'h40);
        check("R10 self add addr", st_addr[1], 32'h80);
        check("R10 self add data", st_data[1], 32'h80);

        // R10 + R9: load into own address register under a long stall
        clear_mem();
        mem[0]  = enc(6'h00, 5'd1, 5'd0, 16'h0);
        mem[1]  = enc(6'h00, 5'd1, 5'd1, 16'h0);
        mem[2]  = enc(6'h01, 5'd1, 5'd1, 16'h0);
        mem[16] = 32'h0000_0100;
        run_prog(5, 1);
        check("R10 self load addr", st_addr[0], 32'h100);
        check("R3 self load data", st_data[0], 32'h100);
        check("R9 stall stability", stall_err, 0);
        check("R8 fetch order stalled", seq_err, 0);

        summary();
        $finish;
    end

endmodule